// File: doc/BRIEF.md
# Directory-Protocol Cache Line Coherence Controller

This block is the cache-side coherence engine for one cache line in a directory-based system that uses the Modified, Owned, Shared and Invalid stable states. The core presents load, store and evict operations. The controller decides whether the line already grants the needed permission. If it does not, it issues a request to the home directory. It then tracks the line through transient states until the directory, the previous owner and the sharers have answered. While the line is not ready, it holds the core with a stall.

The controller also answers traffic from the network on its own. Forwarded read and write requests are served with data when this cache is the owner. Invalidations are acknowledged. Put acknowledgements finish an eviction. The invalidation acknowledgements that a store must collect are tracked in a signed counter. These acknowledgements may arrive before or after the data that announces how many to expect. Races between a pending transaction and a forwarded request are absorbed by extra transient states rather than by stalling the network.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset `line_state` is I (code 0), `req_valid` and `rsp_valid` are low, and `core_stall` is low while `core_valid` is low. Reset in the middle of a transaction also returns the line to I.
- R2: A load (`core_op`=0) in I issues GetS (`req_type`=0) and enters ISD (code 4). Data (`msg_type`=0) in ISD moves the line to S (code 1).
- R3: A store (`core_op`=1) in I or S issues GetM (`req_type`=1) and enters IMAD (5) or SMAD (7). The counter is first cleared. Data adds `msg_ack_cnt` to it, and the line then goes to M (3) if the count is zero, else to IMA (6) or SMA (8).
- R4: Each Inv-Ack (`msg_type`=4) decrements the counter, even before data arrives and even below zero. A line in IMA, SMA or OMA reaches M when an Inv-Ack brings the count to exactly zero.
- R5: An evict (`core_op`=2) in M issues PutM (`req_type`=3) and enters MIA (11). In S it issues PutS (`req_type`=2) and enters SIA (13). Put-Ack (`msg_type`=5) in MIA, OIA, SIA or IIA moves the line to I.
- R6: In MIA, Fwd-GetS (`msg_type`=1) sends data and moves to SIA, and Fwd-GetM (`msg_type`=2) sends data and moves to IIA (14). In OIA (12), Fwd-GetM sends data and moves to IIA.
- R7: Fwd-GetS in IMA records the requestor and moves to IMAS (15). The last Inv-Ack then sends data (`rsp_type`=0) to that requestor with `rsp_to_dir` high and settles in S.
- R8: Fwd-GetS in M sends data to the requestor and moves to O (2). In O it sends data and stays O. Fwd-GetM in M or O sends data and moves to I.
- R9: A store in O issues GetM and enters OMAC (9). The acknowledgement-count message (`msg_type`=6) adds its count and moves to OMA (10), or to M if the count is zero. An evict in O issues PutO (`req_type`=4) and enters OIA (12).
- R10: Inv (`msg_type`=3) in S sends Inv-Ack (`rsp_type`=1) to the message source and moves to I. In SMAD it does the same and moves to IMAD.
- R11: `core_stall` equals `core_valid` unless all of these hold: no message arrives in that cycle, and the operation is permitted (load in S/O/M, store in M, evict in I). A message in the same cycle is handled and the core operation is not acted on.
- R12: Requests and responses appear on the registered outputs one clock after the causing input. Every request leaves from a stable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_valid | input | 1 | Core operation present |
| core_op | input | 2 | 0 load, 1 store, 2 evict |
| core_stall | output | 1 | Core must hold its operation |
| msg_valid | input | 1 | Incoming network message present |
| msg_type | input | 3 | 0 data, 1 Fwd-GetS, 2 Fwd-GetM, 3 Inv, 4 Inv-Ack, 5 Put-Ack, 6 ack-count |
| msg_ack_cnt | input | CNT_W | Acknowledgement count carried with data or ack-count |
| msg_src | input | NODE_W | Sender of the incoming message |
| req_valid | output | 1 | Request to directory valid |
| req_type | output | 3 | 0 GetS, 1 GetM, 2 PutS, 3 PutM, 4 PutO |
| rsp_valid | output | 1 | Response message valid |
| rsp_type | output | 1 | 0 data, 1 Inv-Ack |
| rsp_dest | output | NODE_W | Destination node of the response |
| rsp_to_dir | output | 1 | Data copy also goes to the directory |
| line_state | output | 4 | Current line state code |

## Verification
`core_stall` is combinational and is due in the same cycle that the core and message inputs are driven. The bench reads it 1 ns after driving those inputs on the falling edge. The line state, requests and responses are all registered, so they are due exactly one rising edge after the stimulus. The bench samples them 1 ns after that edge and clears the inputs before the next edge, so that each vector affects exactly one transition. Early Inv-Acks, negative counts and data with a zero count are each placed so that the completing edge is the single sampled one.

// File: rtl/coh_pkg.sv
// Shared encodings for the cache-line coherence controller.
// Assumes one message and one core operation at most per cycle.
package coh_pkg;
    typedef enum logic [3:0] {
        ST_I = 4'd0, ST_S = 4'd1, ST_O = 4'd2, ST_M = 4'd3,
        ST_ISD = 4'd4, ST_IMAD = 4'd5, ST_IMA = 4'd6, ST_SMAD = 4'd7,
        ST_SMA = 4'd8, ST_OMAC = 4'd9, ST_OMA = 4'd10, ST_MIA = 4'd11,
        ST_OIA = 4'd12, ST_SIA = 4'd13, ST_IIA = 4'd14, ST_IMAS = 4'd15
    } line_st_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2, OP_NONE = 2'd3
    } core_op_e;

    typedef enum logic [2:0] {
        MI_DATA = 3'd0, MI_FWD_GETS = 3'd1, MI_FWD_GETM = 3'd2, MI_INV = 3'd3,
        MI_INV_ACK = 3'd4, MI_PUT_ACK = 3'd5, MI_ACK_CNT = 3'd6, MI_RSVD = 3'd7
    } msg_in_e;

    typedef enum logic [2:0] {
        RQ_GETS = 3'd0, RQ_GETM = 3'd1, RQ_PUTS = 3'd2, RQ_PUTM = 3'd3,
        RQ_PUTO = 3'd4, RQ_R5 = 3'd5, RQ_R6 = 3'd6, RQ_R7 = 3'd7
    } req_e;

    typedef enum logic {
        RS_DATA = 1'b0, RS_INV_ACK = 1'b1
    } rsp_e;
endpackage

// File: rtl/coh_ack_counter.sv
// Signed pending-acknowledgement counter.
// Cleared when an ownership request is issued, raised by the announced
// count, lowered by each Inv-Ack. It may go negative when acks beat data.
// Presents the next value so the controller can complete in the same edge.
module coh_ack_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [CNT_W-1:0] add_val,
    input  logic             dec,
    output logic             zero_next
);
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    logic signed [CNT_W-1:0] cnt_q, cnt_d, inc_v, dec_v;

    // next count from this cycle's events
    always_comb begin
        inc_v = add ? $signed(add_val) : '0;
        dec_v = dec ? ONE : '0;
        cnt_d = clr ? '0 : (cnt_q + inc_v - dec_v);
        zero_next = (cnt_d == '0);
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/coh_line_fsm.sv
// Line state machine: stable M/O/S/I plus transient states.
// Messages take priority over the core; a core operation is acted on
// only in a cycle with no message. Outputs are next-cycle intents that
// the output stage registers.
module coh_line_fsm
    import coh_pkg::*;
#(
    parameter int NODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [1:0]        core_op,
    input  logic              msg_valid,
    input  logic [2:0]        msg_type,
    input  logic [NODE_W-1:0] msg_src,
    input  logic              cnt_zero_next,
    output line_st_e          st_q,
    output logic              core_stall,
    output logic              cnt_clr,
    output logic              cnt_add,
    output logic              cnt_dec,
    output logic              req_fire,
    output req_e              req_kind,
    output logic              rsp_fire,
    output rsp_e              rsp_kind,
    output logic [NODE_W-1:0] rsp_dest,
    output logic              rsp_dir
);
    line_st_e          st_d;
    logic [NODE_W-1:0] fwd_src_q;
    logic              fwd_save;
    logic              permit;

    // does the current state grant the core's operation
    always_comb begin
        unique case (core_op_e'(core_op))
            OP_LOAD:  permit = (st_q == ST_S) || (st_q == ST_O) || (st_q == ST_M);
            OP_STORE: permit = (st_q == ST_M);
            OP_EVICT: permit = (st_q == ST_I);
            default:  permit = 1'b0;
        endcase
        core_stall = core_valid && (msg_valid || !permit);
    end

    // transition and message decisions
    always_comb begin
        st_d     = st_q;
        cnt_clr  = 1'b0;
        cnt_add  = 1'b0;
        cnt_dec  = 1'b0;
        req_fire = 1'b0;
        req_kind = RQ_GETS;
        rsp_fire = 1'b0;
        rsp_kind = RS_DATA;
        rsp_dest = msg_src;
        rsp_dir  = 1'b0;
        fwd_save = 1'b0;
        if (msg_valid) begin
            unique case (msg_in_e'(msg_type))
                MI_DATA: begin
                    if (st_q == ST_ISD) st_d = ST_S;
                    else if (st_q == ST_IMAD || st_q == ST_SMAD) begin
                        cnt_add = 1'b1;
                        st_d = cnt_zero_next ? ST_M : ((st_q == ST_IMAD) ? ST_IMA : ST_SMA);
                    end
                end
                MI_ACK_CNT: begin
                    if (st_q == ST_OMAC) begin
                        cnt_add = 1'b1;
                        st_d = cnt_zero_next ? ST_M : ST_OMA;
                    end
                end
                MI_INV_ACK: begin
                    if (st_q inside {ST_IMAD, ST_SMAD, ST_OMAC}) cnt_dec = 1'b1;
                    else if (st_q inside {ST_IMA, ST_SMA, ST_OMA}) begin
                        cnt_dec = 1'b1;
                        if (cnt_zero_next) st_d = ST_M;
                    end else if (st_q == ST_IMAS) begin
                        cnt_dec = 1'b1;
                        if (cnt_zero_next) begin
                            st_d     = ST_S;
                            rsp_fire = 1'b1;
                            rsp_dest = fwd_src_q;
                            rsp_dir  = 1'b1;
                        end
                    end
                end
                MI_FWD_GETS: begin
                    if (st_q inside {ST_M, ST_O, ST_OMAC, ST_OMA, ST_MIA, ST_OIA}) begin
                        rsp_fire = 1'b1;
                        if (st_q == ST_M)   st_d = ST_O;
                        if (st_q == ST_MIA) st_d = ST_SIA;
                    end else if (st_q == ST_IMA) begin
                        st_d     = ST_IMAS;
                        fwd_save = 1'b1;
                    end
                end
                MI_FWD_GETM: begin
                    if (st_q inside {ST_M, ST_O, ST_OMAC, ST_MIA, ST_OIA}) begin
                        rsp_fire = 1'b1;
                        unique case (st_q)
                            ST_OMAC:      st_d = ST_IMAD;
                            ST_MIA, ST_OIA: st_d = ST_IIA;
                            default:      st_d = ST_I;
                        endcase
                    end
                end
                MI_INV: begin
                    if (st_q inside {ST_S, ST_SMAD, ST_SIA}) begin
                        rsp_fire = 1'b1;
                        rsp_kind = RS_INV_ACK;
                        unique case (st_q)
                            ST_SMAD: st_d = ST_IMAD;
                            ST_SIA:  st_d = ST_IIA;
                            default: st_d = ST_I;
                        endcase
                    end
                end
                MI_PUT_ACK: begin
                    if (st_q inside {ST_MIA, ST_OIA, ST_SIA, ST_IIA}) st_d = ST_I;
                end
                default: ;
            endcase
        end else if (core_valid) begin
            unique case (core_op_e'(core_op))
                OP_LOAD: begin
                    if (st_q == ST_I) begin
                        req_fire = 1'b1; req_kind = RQ_GETS; st_d = ST_ISD;
                    end
                end
                OP_STORE: begin
                    if (st_q inside {ST_I, ST_S, ST_O}) begin
                        req_fire = 1'b1; req_kind = RQ_GETM; cnt_clr = 1'b1;
                        unique case (st_q)
                            ST_I:    st_d = ST_IMAD;
                            ST_S:    st_d = ST_SMAD;
                            default: st_d = ST_OMAC;
                        endcase
                    end
                end
                OP_EVICT: begin
                    req_fire = (st_q inside {ST_S, ST_O, ST_M});
                    unique case (st_q)
                        ST_S:    begin req_kind = RQ_PUTS; st_d = ST_SIA; end
                        ST_O:    begin req_kind = RQ_PUTO; st_d = ST_OIA; end
                        ST_M:    begin req_kind = RQ_PUTM; st_d = ST_MIA; end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // line state and recorded forward requestor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_I;
            fwd_src_q <= '0;
        end else begin
            st_q <= st_d;
            if (fwd_save) fwd_src_q <= msg_src;
        end
    end
endmodule

// File: rtl/coh_out_reg.sv
// Registers the outgoing request and response so that every network
// message leaves one clock after the event that caused it.
module coh_out_reg #(
    parameter int NODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic [2:0]        req_kind,
    input  logic              rsp_fire,
    input  logic              rsp_kind,
    input  logic [NODE_W-1:0] rsp_dest,
    input  logic              rsp_dir,
    output logic              req_valid_q,
    output logic [2:0]        req_type_q,
    output logic              rsp_valid_q,
    output logic              rsp_type_q,
    output logic [NODE_W-1:0] rsp_dest_q,
    output logic              rsp_dir_q
);
    // output message register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid_q <= 1'b0;
            req_type_q  <= '0;
            rsp_valid_q <= 1'b0;
            rsp_type_q  <= 1'b0;
            rsp_dest_q  <= '0;
            rsp_dir_q   <= 1'b0;
        end else begin
            req_valid_q <= req_fire;
            req_type_q  <= req_kind;
            rsp_valid_q <= rsp_fire;
            rsp_type_q  <= rsp_kind;
            rsp_dest_q  <= rsp_dest;
            rsp_dir_q   <= rsp_fire && rsp_dir;
        end
    end
endmodule

// File: rtl/coh_cache_ctrl.sv
// Top: cache-side coherence controller for one line under a directory
// protocol with M, O, S and I stable states. Combines the line state
// machine, the acknowledgement counter and the registered output stage.
// Assumes the network delivers at most one message per cycle.
module coh_cache_ctrl
    import coh_pkg::*;
#(
    parameter int NODE_W = 3,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [1:0]        core_op,
    output logic              core_stall,
    input  logic              msg_valid,
    input  logic [2:0]        msg_type,
    input  logic [CNT_W-1:0]  msg_ack_cnt,
    input  logic [NODE_W-1:0] msg_src,
    output logic              req_valid,
    output logic [2:0]        req_type,
    output logic              rsp_valid,
    output logic              rsp_type,
    output logic [NODE_W-1:0] rsp_dest,
    output logic              rsp_to_dir,
    output logic [3:0]        line_state
);
    line_st_e          st_q;
    logic              cnt_clr, cnt_add, cnt_dec, cnt_zero_next;
    logic              req_fire, rsp_fire, rsp_dir;
    req_e              req_kind;
    rsp_e              rsp_kind;
    logic [NODE_W-1:0] rsp_dest_d;

    coh_line_fsm #(.NODE_W(NODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_op(core_op),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_src(msg_src),
        .cnt_zero_next(cnt_zero_next),
        .st_q(st_q), .core_stall(core_stall),
        .cnt_clr(cnt_clr), .cnt_add(cnt_add), .cnt_dec(cnt_dec),
        .req_fire(req_fire), .req_kind(req_kind),
        .rsp_fire(rsp_fire), .rsp_kind(rsp_kind),
        .rsp_dest(rsp_dest_d), .rsp_dir(rsp_dir)
    );

    coh_ack_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(cnt_clr), .add(cnt_add), .add_val(msg_ack_cnt), .dec(cnt_dec),
        .zero_next(cnt_zero_next)
    );

    coh_out_reg #(.NODE_W(NODE_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .req_fire(req_fire), .req_kind(req_kind),
        .rsp_fire(rsp_fire), .rsp_kind(rsp_kind),
        .rsp_dest(rsp_dest_d), .rsp_dir(rsp_dir),
        .req_valid_q(req_valid), .req_type_q(req_type),
        .rsp_valid_q(rsp_valid), .rsp_type_q(rsp_type),
        .rsp_dest_q(rsp_dest), .rsp_dir_q(rsp_to_dir)
    );

    assign line_state = st_q;
endmodule

// File: rtl/coh_cache_ctrl_chk.sv
// Protocol checker bound to the controller top; watches ports only.
module coh_cache_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_valid,
    input logic       core_stall,
    input logic       msg_valid,
    input logic [2:0] msg_type,
    input logic [3:0] line_state,
    input logic       req_valid,
    input logic       rsp_valid,
    input logic       rsp_to_dir
);
    // R11: a transient line never lets a core operation through
    a_r11_stall_transient: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && line_state >= 4'd4) |-> core_stall);

    // R12: requests only leave from a stable state
    a_r12_req_from_stable: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($past(line_state) <= 4'd3));

    // R7: the directory copy only accompanies the IMAS completion
    a_r7_dir_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_to_dir) |-> (line_state == 4'd1 && $past(line_state) == 4'd15));

    // R5: Put-Ack ends a modified eviction
    a_r5_putack_done: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 3'd5 && line_state == 4'd11) |=> (line_state == 4'd0));

    // R8: a forwarded read of a modified line keeps ownership and supplies data
    a_r8_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 3'd1 && line_state == 4'd3) |=> (line_state == 4'd2 && rsp_valid));

    // R2: data fills a pending read into S
    a_r2_fill_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == 3'd0 && line_state == 4'd4) |=> (line_state == 4'd1));
endmodule

bind coh_cache_ctrl coh_cache_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_stall(core_stall),
    .msg_valid(msg_valid), .msg_type(msg_type), .line_state(line_state),
    .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_to_dir(rsp_to_dir)
);

// File: tb/coh_cache_ctrl_bench.sv
// Vector-table bench for the coherence controller, then directed tests.
module coh_cache_ctrl_bench;
    typedef struct packed {
        logic       cv;    logic [1:0] op;
        logic       mv;    logic [2:0] mt;  logic [4:0] ac;  logic [2:0] src;
        logic       xs;    logic [3:0] xst;
        logic       xrq;   logic [2:0] xrqt;
        logic       xrs;   logic       xrst; logic [2:0] xdst; logic xdir;
        logic [3:0] rq;
    } vec_t;

    // cv op mv mt ac src | stall state | rq rqt | rs rst dst dir | req
    localparam vec_t VEC [47] = '{
        '{1,0,0,0,0,0, 1,4,  1,0, 0,0,0,0, 2},  // R2 load I -> GetS, ISD
        '{0,0,1,0,0,0, 0,1,  0,0, 0,0,0,0, 2},  // R2 data -> S
        '{1,0,0,0,0,0, 0,1,  0,0, 0,0,0,0, 11}, // R11 load hit in S
        '{1,1,0,0,0,0, 1,7,  1,1, 0,0,0,0, 3},  // R3 store S -> GetM, SMAD
        '{0,0,1,4,0,2, 0,7,  0,0, 0,0,0,0, 4},  // R4 early Inv-Ack, count -1
        '{0,0,1,0,2,0, 0,8,  0,0, 0,0,0,0, 4},  // R4 data count 2 -> SMA
        '{0,0,1,4,0,2, 0,3,  0,0, 0,0,0,0, 4},  // R4 last Inv-Ack -> M
        '{1,1,0,0,0,0, 0,3,  0,0, 0,0,0,0, 11}, // R11 store hit in M
        '{0,0,1,1,0,5, 0,2,  0,0, 1,0,5,0, 8},  // R8 Fwd-GetS in M -> O
        '{0,0,1,1,0,6, 0,2,  0,0, 1,0,6,0, 8},  // R8 Fwd-GetS in O stays
        '{1,1,0,0,0,0, 1,9,  1,1, 0,0,0,0, 9},  // R9 store O -> OMAC
        '{0,0,1,6,1,0, 0,10, 0,0, 0,0,0,0, 9},  // R9 ack-count 1 -> OMA
        '{0,0,1,4,0,3, 0,3,  0,0, 0,0,0,0, 9},  // R9 Inv-Ack -> M
        '{1,2,0,0,0,0, 1,11, 1,3, 0,0,0,0, 5},  // R5 evict M -> PutM, MIA
        '{0,0,1,1,0,3, 0,13, 0,0, 1,0,3,0, 6},  // R6 Fwd-GetS in MIA -> SIA
        '{0,0,1,5,0,0, 0,0,  0,0, 0,0,0,0, 6},  // R6 Put-Ack -> I
        '{1,2,0,0,0,0, 0,0,  0,0, 0,0,0,0, 11}, // R11 evict in I is done
        '{1,1,0,0,0,0, 1,5,  1,1, 0,0,0,0, 3},  // R3 store I -> IMAD
        '{0,0,1,0,1,0, 0,6,  0,0, 0,0,0,0, 3},  // R3 data count 1 -> IMA
        '{0,0,1,1,0,4, 0,15, 0,0, 0,0,0,0, 7},  // R7 Fwd-GetS in IMA -> IMAS
        '{0,0,1,4,0,1, 0,1,  0,0, 1,0,4,1, 7},  // R7 last ack -> S, data to 4 and dir
        '{0,0,1,3,0,7, 0,0,  0,0, 1,1,7,0, 10}, // R10 Inv in S -> I, Inv-Ack
        '{1,1,0,0,0,0, 1,5,  1,1, 0,0,0,0, 3},  // R3 store I
        '{0,0,1,0,0,0, 0,3,  0,0, 0,0,0,0, 3},  // R3 data count 0 -> M
        '{0,0,1,2,0,1, 0,0,  0,0, 1,0,1,0, 8},  // R8 Fwd-GetM in M -> I
        '{1,0,0,0,0,0, 1,4,  1,0, 0,0,0,0, 2},  // R2 load I
        '{0,0,1,0,0,0, 0,1,  0,0, 0,0,0,0, 2},  // R2 data
        '{1,1,0,0,0,0, 1,7,  1,1, 0,0,0,0, 3},  // R3 store S
        '{0,0,1,3,0,2, 0,5,  0,0, 1,1,2,0, 10}, // R10 Inv in SMAD -> IMAD
        '{0,0,1,0,0,0, 0,3,  0,0, 0,0,0,0, 3},  // R3 data count 0 -> M
        '{0,0,1,1,0,3, 0,2,  0,0, 1,0,3,0, 8},  // R8 M -> O
        '{1,2,0,0,0,0, 1,12, 1,4, 0,0,0,0, 9},  // R9 evict O -> PutO, OIA
        '{0,0,1,2,0,4, 0,14, 0,0, 1,0,4,0, 6},  // R6 Fwd-GetM in OIA -> IIA
        '{0,0,1,5,0,0, 0,0,  0,0, 0,0,0,0, 6},  // R6 Put-Ack -> I
        '{1,1,0,0,0,0, 1,5,  1,1, 0,0,0,0, 3},  // R3 store I
        '{0,0,1,0,0,0, 0,3,  0,0, 0,0,0,0, 3},  // R3 data -> M
        '{1,2,0,0,0,0, 1,11, 1,3, 0,0,0,0, 5},  // R5 evict M
        '{0,0,1,2,0,5, 0,14, 0,0, 1,0,5,0, 6},  // R6 Fwd-GetM in MIA -> IIA
        '{0,0,1,5,0,0, 0,0,  0,0, 0,0,0,0, 6},  // R6 Put-Ack -> I
        '{1,0,0,0,0,0, 1,4,  1,0, 0,0,0,0, 2},  // R2 load I
        '{0,0,1,0,0,0, 0,1,  0,0, 0,0,0,0, 2},  // R2 data
        '{1,2,0,0,0,0, 1,13, 1,2, 0,0,0,0, 5},  // R5 evict S -> PutS, SIA
        '{0,0,1,5,0,0, 0,0,  0,0, 0,0,0,0, 5},  // R5 Put-Ack -> I
        '{1,0,0,0,0,0, 1,4,  1,0, 0,0,0,0, 2},  // R2 load I
        '{1,0,0,0,0,0, 1,4,  0,0, 0,0,0,0, 11}, // R11 load while ISD stalls, no request
        '{0,0,1,0,0,0, 0,1,  0,0, 0,0,0,0, 2},  // R2 data
        '{1,1,1,3,0,6, 1,0,  0,0, 1,1,6,0, 11}  // R11 Inv beats store in S
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_valid = 1'b0;
    logic [1:0] core_op = '0;
    logic       core_stall;
    logic       msg_valid = 1'b0;
    logic [2:0] msg_type = '0;
    logic [4:0] msg_ack_cnt = '0;
    logic [2:0] msg_src = '0;
    logic       req_valid, rsp_valid, rsp_type, rsp_to_dir;
    logic [2:0] req_type, rsp_dest;
    logic [3:0] line_state;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    coh_cache_ctrl u_coh_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_op(core_op),
        .core_stall(core_stall), .msg_valid(msg_valid), .msg_type(msg_type),
        .msg_ack_cnt(msg_ack_cnt), .msg_src(msg_src), .req_valid(req_valid),
        .req_type(req_type), .rsp_valid(rsp_valid), .rsp_type(rsp_type),
        .rsp_dest(rsp_dest), .rsp_to_dir(rsp_to_dir), .line_state(line_state)
    );

    task automatic chk(input bit ok, input int rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // drive on the falling edge, stall read 1 ns later, registered outputs 1 ns after the rising edge
    task automatic run_vec(input vec_t v);
        @(negedge clk);
        core_valid = v.cv; core_op = v.op; msg_valid = v.mv;
        msg_type = v.mt; msg_ack_cnt = v.ac; msg_src = v.src;
        #1;
        chk(core_stall == v.xs, int'(v.rq), "stall", int'(core_stall), int'(v.xs));
        @(posedge clk);
        #1;
        chk(line_state == v.xst, int'(v.rq), "state", int'(line_state), int'(v.xst));
        chk(req_valid == v.xrq, int'(v.rq), "req_valid", int'(req_valid), int'(v.xrq));
        if (v.xrq) chk(req_type == v.xrqt, int'(v.rq), "req_type", int'(req_type), int'(v.xrqt));
        chk(rsp_valid == v.xrs, int'(v.rq), "rsp_valid", int'(rsp_valid), int'(v.xrs));
        if (v.xrs) begin
            chk(rsp_type == v.xrst, int'(v.rq), "rsp_type", int'(rsp_type), int'(v.xrst));
            chk(rsp_dest == v.xdst, int'(v.rq), "rsp_dest", int'(rsp_dest), int'(v.xdst));
            chk(rsp_to_dir == v.xdir, int'(v.rq), "rsp_to_dir", int'(rsp_to_dir), int'(v.xdir));
        end
        core_valid = 1'b0; msg_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(line_state == 4'd0, 1, "reset state", int'(line_state), 0);
        chk(req_valid == 1'b0, 1, "reset req", int'(req_valid), 0);
        chk(rsp_valid == 1'b0, 1, "reset rsp", int'(rsp_valid), 0);
        chk(core_stall == 1'b0, 1, "reset stall", int'(core_stall), 0);

        for (int i = 0; i < 47; i++) run_vec(VEC[i]);

        // R4 two acks ahead of data, count reaches zero exactly on data -> M
        run_vec('{1,1,0,0,0,0, 1,5,  1,1, 0,0,0,0, 4});
        run_vec('{0,0,1,4,0,3, 0,5,  0,0, 0,0,0,0, 4});
        run_vec('{0,0,1,4,0,4, 0,5,  0,0, 0,0,0,0, 4});
        run_vec('{0,0,1,0,2,0, 0,3,  0,0, 0,0,0,0, 4});
        run_vec('{0,0,1,2,0,2, 0,0,  0,0, 1,0,2,0, 8});

        // R1 reset in the middle of a transaction
        run_vec('{1,1,0,0,0,0, 1,5,  1,1, 0,0,0,0, 1});
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(line_state == 4'd0, 1, "mid reset state", int'(line_state), 0);
        chk(req_valid == 1'b0, 1, "mid reset req", int'(req_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 the line works again after reset
        run_vec('{1,0,0,0,0,0, 1,4,  1,0, 0,0,0,0, 2});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule